// File: doc/BRIEF.md
# Runt-Free Differential Clock Output Gate

This block sits between a clock source and the output drivers of a differential clock fan-out stage. It drives six gated true/complement output pairs and one feedback pair from a selected source clock. A static bypass strap picks the source: the reference input when the loop is switched off for test, or the loop output in normal operation. Each pair has its own output-enable line, which the pad stage uses to tri-state the true and complement lines together.

Per-pair enable bits arrive from a configuration register in an unrelated clock domain. They are synchronized into the source-clock domain and take effect only on a falling edge of the source clock. A pair therefore starts and stops on a whole pulse. The feedback pair ignores the enable bits.

A monitor runs on a free-running measurement clock and counts reference rising edges over a fixed window. If the reference is too slow, or has stopped, it tri-states every output, including the feedback pair. It lifts that condition only after enough consecutive good windows. There is no data stream through this block, so every pin is a plain level or clock signal with no handshake.

Top module: `clkout_gate`

## Requirements
- R1: Whenever a pair's output-enable is 1, its complement line is the inverse of its true line. This holds for the six gated pairs and the feedback pair.
- R2: Whenever a pair's output-enable is 0, both of its lines are parked at 0 and the pad treats the pair as high impedance.
- R3: Bit i of `pair_en` (1 = drive) controls gated pair i. A change on that bit shows on `out_oe[i]` at the first falling source edge after two rising source edges have sampled it, so an enable never changes during a high phase.
- R4: The feedback pair's output-enable stays 1 for any value of `pair_en` while the reference is judged fast enough.
- R5: The true lines follow `ref_clk` when `bypass` is 1 and `pll_clk` when `bypass` is 0; the complement lines carry the inverse.
- R6: A measurement window of WINDOW `meas_clk` cycles that holds fewer than MIN_EDGES reference rising edges forces every output-enable, the feedback pair's included, to 0 until release.
- R7: A reference that has stopped at either level is judged too slow, as in R6.
- R8: Release after R6 or R7 requires GOOD_WINDOWS (default 2) consecutive good windows, so the outputs stay disabled for at least one full window after the reference recovers. The enables then return to the `pair_en` values at a falling source edge.
- R9: During reset and after it, every output-enable is 0. The reference is treated as too slow until the windows of R8 have passed, and only then do the gated pairs take their `pair_en` values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| meas_clk | input | 1 | Free-running measurement clock for the frequency monitor |
| rst_n | input | 1 | Active-low asynchronous reset for all domains |
| ref_clk | input | 1 | Reference clock input |
| pll_clk | input | 1 | Loop output clock used when bypass is off |
| bypass | input | 1 | Static strap: 1 selects ref_clk as the source |
| pair_en | input | PAIRS | Per-pair drive enable, 1 = driven |
| out_t | output | PAIRS | True lines of the gated pairs |
| out_c | output | PAIRS | Complement lines of the gated pairs |
| out_oe | output | PAIRS | Output-enable of each gated pair |
| fb_t | output | 1 | Feedback true line |
| fb_c | output | 1 | Feedback complement line |
| fb_oe | output | 1 | Feedback output-enable |

## Verification
Enable patterns are applied with all bits set, all bits clear, alternating bits and walking single bits. Some patterns are held for less than one source period, which shows whether the two-stage synchronizer and the falling-edge update apply the right value on the right edge. The same patterns run with the loop clock, then in bypass with the loop clock stopped. That second run tells real reference-following apart from a fixed source select. The reference is then slowed, restored and stopped. These cases separate an immediate forced tri-state from the delayed two-window release, and a truly missing reference from a slow one.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  // Drive state of one differential output pair
  typedef struct packed {
    logic oe;
    logic t;
    logic c;
  } pin_pair_t;

  // Lines are parked low whenever the pair is not driven
  function automatic pin_pair_t drive_pair(input logic src, input logic oe);
    pin_pair_t p;
    p.oe = oe;
    p.t  = src & oe;
    p.c  = ~src & oe;
    return p;
  endfunction

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/refclk_monitor.sv
module refclk_monitor #(
  parameter int WINDOW = 64,
  parameter int MIN_EDGES = 8,
  parameter int GOOD_WINDOWS = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic meas_clk,
  input  logic rst_n,
  input  logic ref_clk,
  output logic ref_slow
);
  localparam int WIN_W  = $clog2(WINDOW);
  localparam int CNT_W  = $clog2(WINDOW + 1);
  localparam int GOOD_W = $clog2(GOOD_WINDOWS + 1);

  logic ref_s, ref_d, ref_rise;
  logic [WIN_W-1:0]  win_cnt;
  logic [CNT_W-1:0]  edge_cnt, edge_total;
  logic [GOOD_W-1:0] good_cnt;
  logic win_end, win_good;

  ctl_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ref_sync (
    .clk(meas_clk), .rst_n(rst_n), .d(ref_clk), .q(ref_s)
  );

  always_ff @(posedge meas_clk or negedge rst_n) begin
    if (!rst_n) ref_d <= 1'b0;
    else        ref_d <= ref_s;
  end

  assign ref_rise   = ref_s & ~ref_d;
  assign win_end    = (win_cnt == WIN_W'(WINDOW - 1));
  assign edge_total = edge_cnt + CNT_W'(ref_rise);
  assign win_good   = (edge_total >= CNT_W'(MIN_EDGES));

  always_ff @(posedge meas_clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
      good_cnt <= '0;
      ref_slow <= 1'b1;
    end else begin
      win_cnt  <= win_end ? '0 : win_cnt + 1'b1;
      edge_cnt <= win_end ? '0 : edge_total;
      if (win_end) begin
        if (!win_good) begin
          ref_slow <= 1'b1;
          good_cnt <= '0;
        end else if (ref_slow) begin
          if (good_cnt == GOOD_W'(GOOD_WINDOWS - 1)) begin
            ref_slow <= 1'b0;
            good_cnt <= '0;
          end else begin
            good_cnt <= good_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pair_gate.sv
module pair_gate
  import clkgate_pkg::*;
(
  input  logic      src_clk,
  input  logic      rst_n,
  input  logic      en_s,
  input  logic      force_off,
  output pin_pair_t pins
);
  logic oe_q;

  // Updated only on the falling edge, while the source clock is low
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= en_s;
  end

  assign pins = drive_pair(src_clk, oe_q & ~force_off);
endmodule

// File: rtl/clkout_gate.sv
module clkout_gate
  import clkgate_pkg::*;
#(
  parameter int PAIRS = 6,
  parameter int WINDOW = 64,
  parameter int MIN_EDGES = 8,
  parameter int GOOD_WINDOWS = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             meas_clk,
  input  logic             rst_n,
  input  logic             ref_clk,
  input  logic             pll_clk,
  input  logic             bypass,
  input  logic [PAIRS-1:0] pair_en,
  output logic [PAIRS-1:0] out_t,
  output logic [PAIRS-1:0] out_c,
  output logic [PAIRS-1:0] out_oe,
  output logic             fb_t,
  output logic             fb_c,
  output logic             fb_oe
);
  localparam int CTL_W = PAIRS + 1;
  localparam logic [CTL_W-1:0] CTL_RST = {1'b1, {PAIRS{1'b0}}};

  logic src_clk;
  logic ref_slow;
  logic slow_s;
  logic [PAIRS-1:0] en_s;
  logic [CTL_W-1:0] ctl_q;
  pin_pair_t pair_pins [PAIRS];
  pin_pair_t fb_pins;

  // Static strap selects the source clock
  assign src_clk = bypass ? ref_clk : pll_clk;

  refclk_monitor #(
    .WINDOW(WINDOW), .MIN_EDGES(MIN_EDGES),
    .GOOD_WINDOWS(GOOD_WINDOWS), .SYNC_STAGES(SYNC_STAGES)
  ) u_mon (
    .meas_clk(meas_clk), .rst_n(rst_n), .ref_clk(ref_clk), .ref_slow(ref_slow)
  );

  // Enables and the slow flag move into the source-clock domain together
  ctl_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_ctl_sync (
    .clk(src_clk), .rst_n(rst_n), .d({ref_slow, pair_en}), .q(ctl_q)
  );

  assign slow_s = ctl_q[PAIRS];
  assign en_s   = ctl_q[PAIRS-1:0];

  generate
    for (genvar i = 0; i < PAIRS; i++) begin : g_pair
      pair_gate u_gate (
        .src_clk(src_clk), .rst_n(rst_n),
        .en_s(en_s[i] & ~slow_s), .force_off(ref_slow),
        .pins(pair_pins[i])
      );
      assign out_t[i]  = pair_pins[i].t;
      assign out_c[i]  = pair_pins[i].c;
      assign out_oe[i] = pair_pins[i].oe;
    end
  endgenerate

  // Feedback pair: no per-pair enable, only the slow-reference condition
  pair_gate u_fb_gate (
    .src_clk(src_clk), .rst_n(rst_n),
    .en_s(~slow_s), .force_off(ref_slow),
    .pins(fb_pins)
  );
  assign fb_t  = fb_pins.t;
  assign fb_c  = fb_pins.c;
  assign fb_oe = fb_pins.oe;
endmodule

// File: rtl/clkout_gate_chk.sv
module clkout_gate_chk #(
  parameter int PAIRS = 6
) (
  input logic             meas_clk,
  input logic             rst_n,
  input logic             src_clk,
  input logic             ref_slow,
  input logic [PAIRS-1:0] out_t,
  input logic [PAIRS-1:0] out_c,
  input logic [PAIRS-1:0] out_oe,
  input logic             fb_t,
  input logic             fb_c,
  input logic             fb_oe
);
  logic [PAIRS-1:0] oe_at_rise;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) oe_at_rise <= '0;
    else        oe_at_rise <= out_oe;
  end

  generate
    for (genvar i = 0; i < PAIRS; i++) begin : g_chk
      // R1
      compl_chk: assert property (@(posedge meas_clk) disable iff (!rst_n)
        out_oe[i] |-> (out_c[i] == ~out_t[i]));
      // R2
      park_chk: assert property (@(posedge meas_clk) disable iff (!rst_n)
        !out_oe[i] |-> (!out_t[i] && !out_c[i]));
      // R3
      no_runt_chk: assert property (@(negedge src_clk) disable iff (!rst_n || ref_slow)
        out_oe[i] == oe_at_rise[i]);
    end
  endgenerate

  // R1
  fb_compl_chk: assert property (@(posedge meas_clk) disable iff (!rst_n)
    fb_oe |-> (fb_c == ~fb_t));
  // R4
  fb_driven_chk: assert property (@(posedge meas_clk) disable iff (!rst_n)
    (|out_oe) |-> fb_oe);
  // R6
  slow_off_chk: assert property (@(posedge meas_clk) disable iff (!rst_n)
    ref_slow |-> (out_oe == '0 && !fb_oe));
endmodule

bind clkout_gate clkout_gate_chk #(.PAIRS(PAIRS)) u_chk (
  .meas_clk(meas_clk), .rst_n(rst_n), .src_clk(src_clk), .ref_slow(ref_slow),
  .out_t(out_t), .out_c(out_c), .out_oe(out_oe),
  .fb_t(fb_t), .fb_c(fb_c), .fb_oe(fb_oe)
);

// File: tb/test_clkout_gate.sv
module test_clkout_gate;
  localparam int WIN = 64;

  logic meas_clk = 1'b0;
  logic rst_n, ref_clk, pll_clk, bypass;
  logic [5:0] pair_en, out_t, out_c, out_oe;
  logic fb_t, fb_c, fb_oe;
  int   ref_half = 16;
  bit   ref_run = 1, pll_run = 1, chk_on = 0, done = 0;
  int   n_chk = 0, n_err = 0;

  clkout_gate #(.PAIRS(6), .WINDOW(WIN), .MIN_EDGES(8), .GOOD_WINDOWS(2), .SYNC_STAGES(2))
  i_clkout_gate (
    .meas_clk(meas_clk), .rst_n(rst_n), .ref_clk(ref_clk), .pll_clk(pll_clk),
    .bypass(bypass), .pair_en(pair_en), .out_t(out_t), .out_c(out_c),
    .out_oe(out_oe), .fb_t(fb_t), .fb_c(fb_c), .fb_oe(fb_oe)
  );

  always #4 meas_clk = ~meas_clk;   // 125 MHz

  initial begin
    ref_clk = 1'b0; #1;
    forever begin
      if (ref_run) #(ref_half) ref_clk = ~ref_clk;
      else #2;
    end
  end

  initial begin
    pll_clk = 1'b0; #3;
    forever begin
      if (pll_run) #12 pll_clk = ~pll_clk;
      else #2;
    end
  end

  // Reference model: enable seen at two rising edges, applied at next falling edge
  logic m_src;
  logic [5:0] m_oe;
  logic [5:0] en_hist [$];
  assign m_src = bypass ? ref_clk : pll_clk;

  always @(posedge m_src or negedge rst_n) begin
    if (!rst_n) en_hist.delete();
    else begin
      en_hist.push_back(pair_en);
      if (en_hist.size() > 2) void'(en_hist.pop_front());
    end
  end

  always @(negedge m_src or negedge rst_n) begin
    if (!rst_n) m_oe = '0;
    else m_oe = (en_hist.size() == 2) ? en_hist[0] : 6'h00;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge meas_clk) begin
    if (chk_on && rst_n) begin
      logic [5:0] et, ec;
      et = m_oe & {6{m_src}};
      ec = m_oe & {6{~m_src}};
      if (out_oe != m_oe)
        chk(0, "R3 oe timing", {26'd0, out_oe}, {26'd0, m_oe});
      else if (out_t != et || out_c != ec)
        chk(0, bypass ? "R5 lines" : "R1 R2 lines", {20'd0, out_t, out_c}, {20'd0, et, ec});
      else if (!fb_oe || fb_t != m_src || fb_c != ~m_src)
        chk(0, "R4 feedback", {29'd0, fb_oe, fb_t, fb_c}, {29'd0, 1'b1, m_src, ~m_src});
      else
        chk(1, "", 0, 0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge meas_clk);
  endtask

  task automatic run_patterns();
    logic [5:0] pats [10] = '{6'h3F, 6'h00, 6'h15, 6'h2A, 6'h01, 6'h02, 6'h04, 6'h08, 6'h10, 6'h20};
    int holds [10] = '{20, 1, 9, 2, 14, 3, 7, 1, 11, 25};
    for (int k = 0; k < 10; k++) begin
      @(posedge meas_clk) pair_en = pats[k];
      cyc(holds[k]);
    end
    cyc(12);
  endtask

  initial begin
    rst_n = 1'b0; bypass = 1'b0; pair_en = 6'b110101;
    cyc(6); @(negedge meas_clk);
    chk(out_oe == 0 && fb_oe == 0, "R9 reset oe", {25'd0, out_oe, fb_oe}, 0);
    chk(out_t == 0 && out_c == 0 && !fb_t && !fb_c, "R2 reset lines", {18'd0, out_t, out_c, fb_t, fb_c}, 0);
    @(posedge meas_clk) rst_n = 1'b1;
    cyc(8); @(negedge meas_clk);
    chk(fb_oe == 0 && out_oe == 0, "R9 held off before good windows", {25'd0, out_oe, fb_oe}, 0);
    cyc(5 * WIN); @(negedge meas_clk);
    chk(fb_oe == 1, "R8 release after reset", {31'd0, fb_oe}, 1);
    chk(out_oe == pair_en, "R9 enables after release", {26'd0, out_oe}, {26'd0, pair_en});

    chk_on = 1;
    run_patterns();
    @(posedge meas_clk) pair_en = 6'h00;
    cyc(20); @(negedge meas_clk);
    chk(fb_oe == 1 && out_oe == 0, "R4 feedback with all pairs off", {25'd0, out_oe, fb_oe}, 1);

    // Bypass: source is the reference
    chk_on = 0;
    @(posedge meas_clk) bypass = 1'b1;
    cyc(12); chk_on = 1;
    run_patterns();
    pll_run = 0;
    run_patterns();
    @(posedge meas_clk) pair_en = 6'h3F;
    cyc(12);
    for (int k = 0; k < 6; k++) begin
      @(negedge meas_clk);
      chk(out_t == {6{ref_clk}} && out_c == {6{~ref_clk}}, "R5 bypass follows reference",
          {20'd0, out_t, out_c}, {20'd0, {6{ref_clk}}, {6{~ref_clk}}});
    end
    chk_on = 0;
    pll_run = 1;
    @(posedge meas_clk) bypass = 1'b0;
    cyc(12); chk_on = 1;
    run_patterns();

    // Slow reference
    chk_on = 0;
    @(posedge meas_clk) pair_en = 6'h3F;
    ref_half = 160;
    cyc(3 * WIN);
    for (int k = 0; k < 5; k++) begin
      cyc(7); @(negedge meas_clk);
      chk(out_oe == 0 && fb_oe == 0 && out_t == 0 && out_c == 0 && !fb_t,
          "R6 slow reference tri-states all", {18'd0, out_oe, out_t, fb_oe, fb_t}, 0);
    end
    ref_half = 16;
    cyc(WIN - 4); @(negedge meas_clk);
    chk(fb_oe == 0 && out_oe == 0, "R8 still off after one window", {25'd0, out_oe, fb_oe}, 0);
    cyc(3 * WIN); @(negedge meas_clk);
    chk(fb_oe == 1 && out_oe == 6'h3F, "R8 released after good windows", {25'd0, out_oe, fb_oe}, {25'd0, 6'h3F, 1'b1});

    // Stopped reference
    ref_run = 0;
    cyc(3 * WIN); @(negedge meas_clk);
    chk(fb_oe == 0 && out_oe == 0, "R7 stopped reference", {25'd0, out_oe, fb_oe}, 0);
    ref_run = 1;
    cyc(4 * WIN); @(negedge meas_clk);
    chk(fb_oe == 1 && out_oe == 6'h3F, "R7 recovery", {25'd0, out_oe, fb_oe}, {25'd0, 6'h3F, 1'b1});
    chk_on = 1;
    run_patterns();
    chk_on = 0;

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog R9 actual=%h expected=%h", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule